// File: doc/BRIEF.md
# Per-Channel Burst Filter

This block sits on a wide receive datapath that carries bursts for two logical channels, interleaved word by word. Every clock cycle it accepts one beat of four 64-bit words. A per-word flag marks each word as data or control. The block follows burst and idle control words to track which channel owns the words that come next. It keeps only the words that belong to its own channel, which is set by a parameter. Words for the other channel are dropped.

The kept words in a beat are moved toward the most significant lanes. They leave no gaps and keep their original order. The block emits them one cycle later, together with a valid flag and a control flag for each lane. Channel ownership can change in the middle of a beat. One control word can close one channel's packet and open the other's. When that happens, each of the two filter instances receives a rewritten copy of the word that carries only its own part. Control words are passed on, not removed.

Top module: `bfilt_chan`

## Requirements
- R1: After reset, all output lane valid and control flags are low. The ownership state is cleared.
- R2: A data word is kept only while this filter's channel owns the datapath. The kept word appears on the outputs exactly one cycle after its beat is accepted. Data words of the other channel never appear.
- R3: Within an output beat, the kept words fill lanes downward from the most significant lane with no gaps. Their order is the input order, and the most significant input lane (bits 255:192) is the earliest word.
- R4: The control word layout is: bit 63 is the type (1 = burst, 0 = idle), bit 62 is start-of-packet, bit 61 is end-of-packet, bits 60:58 hold the valid-byte count of the last data word, and bits 55:48 hold the channel number. Ownership is taken only at a burst word with start-of-packet set, and it takes the channel number in that word.
- R5: A control word that ends this channel's packet and starts the other channel's is split between the two filters. The closing filter outputs it with start-of-packet cleared and its byte count intact. The opening filter outputs it with end-of-packet cleared and a zero byte count. In both copies the channel field holds the receiving filter's own channel.
- R6: A control word with end-of-packet set, burst or idle, is passed to the filter whose channel is active at that point. It ends ownership, so later data words are dropped until the next start-of-packet.
- R7: An ownership change takes effect for the lanes after the control word within the same beat.
- R8: Data words that arrive before any burst start-of-packet since reset are dropped.
- R9: A beat with no word for this channel produces an output beat with every lane valid flag low.
- R10: Output lanes whose valid flag is low carry all-zero data and a low control flag.
- R11: A beat presented with in_valid low produces no output words and does not change ownership.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat qualifier |
| in_data | input | 256 | Four words; bits 255:192 are the earliest |
| in_ctl | input | 4 | Per-lane control flag; bit 3 belongs to the earliest word |
| out_data | output | 256 | Packed kept words, earliest in bits 255:192 |
| out_vld | output | 4 | Per-lane valid flag |
| out_ctl | output | 4 | Per-lane control flag |

## Verification
The assertions check, on every cycle, the properties that hold regardless of the traffic. The valid lanes must form a single run from the most significant lane. Invalid lanes must carry zero data and no control flag. A beat with in_valid low must produce an empty output, and the output must be empty after reset. Whether the correct words survive is something only the bench scenarios can show. That covers ownership handoff in the middle of a beat, the splitting of a shared control word, an idle word that closes a packet, data dropped before the first burst, and ownership held across a beat with in_valid low. For these, the bench runs one instance for each channel and compares both against beats it computes itself.

// File: rtl/bfilt_pkg.sv
package bfilt_pkg;
   // control word field positions; neighbours decode these
   localparam int unsigned CW_TYPE_BIT = 63;
   localparam int unsigned CW_SOP_BIT  = 62;
   localparam int unsigned CW_EOP_BIT  = 61;
   localparam int unsigned CW_CNT_LO   = 58;
   localparam int unsigned CNT_W       = 3;
   localparam int unsigned CW_CH_LO    = 48;
   localparam int unsigned CH_W        = 8;

   typedef struct packed {
      logic             is_ctl;
      logic             is_burst;
      logic             sop;
      logic             eop;
      logic [CNT_W-1:0] cnt;
      logic [CH_W-1:0]  ch;
   } lane_info_t;

   typedef struct packed {
      logic keep;
      logic sop;
      logic eop;
   } lane_verdict_t;
endpackage

// File: rtl/bfilt_lane_dec.sv
module bfilt_lane_dec
   import bfilt_pkg::*;
#(
   parameter int unsigned WORD_W = 64
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic              ctl_i,
   output lane_info_t        info_o
);
   logic unused_bits;
   assign unused_bits = ^word_i;

   always_comb begin
      info_o.is_ctl   = ctl_i;
      info_o.is_burst = ctl_i & word_i[CW_TYPE_BIT];
      // start-of-packet only has meaning on a burst word
      info_o.sop      = ctl_i & word_i[CW_TYPE_BIT] & word_i[CW_SOP_BIT];
      info_o.eop      = ctl_i & word_i[CW_EOP_BIT];
      info_o.cnt      = word_i[CW_CNT_LO +: CNT_W];
      info_o.ch       = word_i[CW_CH_LO +: CH_W];
   end
endmodule

// File: rtl/bfilt_owner_walk.sv
module bfilt_owner_walk
   import bfilt_pkg::*;
#(
   parameter int unsigned    LANES = 4,
   parameter logic [CH_W-1:0] MY_CH = '0
) (
   input  lane_info_t    [LANES-1:0] info_i,
   input  logic                      beat_vld_i,
   input  logic                      act_q_i,
   input  logic [CH_W-1:0]           own_q_i,
   output lane_verdict_t [LANES-1:0] verd_o,
   output logic                      act_d_o,
   output logic [CH_W-1:0]           own_d_o
);
   logic unused_fields;
   assign unused_fields = ^info_i;

   // walk lanes from the earliest (top) to the latest, updating ownership
   always_comb begin : walk
      logic            act;
      logic [CH_W-1:0] own;
      logic            mine;
      logic            sop_me;
      logic            eop_me;
      act    = act_q_i;
      own    = own_q_i;
      verd_o = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
         mine   = act && (own == MY_CH);
         sop_me = info_i[i].sop && (info_i[i].ch == MY_CH);
         eop_me = info_i[i].eop && mine;
         if (!info_i[i].is_ctl) begin
            verd_o[i].keep = mine & beat_vld_i;
         end else begin
            verd_o[i].sop  = sop_me;
            verd_o[i].eop  = eop_me;
            verd_o[i].keep = beat_vld_i &
                             (sop_me | eop_me | (!info_i[i].sop && !info_i[i].eop && mine));
            if (info_i[i].eop) act = 1'b0;
            if (info_i[i].sop) begin
               act = 1'b1;
               own = info_i[i].ch;
            end
         end
      end
      act_d_o = beat_vld_i ? act : act_q_i;
      own_d_o = beat_vld_i ? own : own_q_i;
   end
endmodule

// File: rtl/bfilt_pack.sv
module bfilt_pack #(
   parameter int unsigned LANES  = 4,
   parameter int unsigned WORD_W = 64
) (
   input  logic [LANES-1:0][WORD_W-1:0] word_i,
   input  logic [LANES-1:0]             keep_i,
   input  logic [LANES-1:0]             ctl_i,
   output logic [LANES-1:0][WORD_W-1:0] word_o,
   output logic [LANES-1:0]             vld_o,
   output logic [LANES-1:0]             ctl_o
);
   localparam int unsigned IDX_W = $clog2(LANES);

   always_comb begin : squeeze
      logic [IDX_W-1:0] pos;
      pos    = IDX_W'(LANES - 1);
      word_o = '0;
      vld_o  = '0;
      ctl_o  = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (keep_i[i]) begin
            word_o[pos] = word_i[i];
            vld_o[pos]  = 1'b1;
            ctl_o[pos]  = ctl_i[i];
            pos         = pos - 1'b1;
         end
      end
   end
endmodule

// File: rtl/bfilt_chan.sv
module bfilt_chan
   import bfilt_pkg::*;
#(
   parameter int unsigned LANES  = 4,
   parameter int unsigned WORD_W = 64,
   parameter int unsigned MY_CH  = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [LANES*WORD_W-1:0]   in_data,
   input  logic [LANES-1:0]          in_ctl,
   output logic [LANES*WORD_W-1:0]   out_data,
   output logic [LANES-1:0]          out_vld,
   output logic [LANES-1:0]          out_ctl
);
   localparam logic [CH_W-1:0] MY_CH_V = CH_W'(MY_CH);

   generate
      if (LANES < 2) begin : g_bad_lanes
         $error("bfilt_chan: LANES must be at least 2");
      end
      if (WORD_W <= CW_TYPE_BIT) begin : g_bad_width
         $error("bfilt_chan: WORD_W too narrow for the control word fields");
      end
      if (MY_CH >= (1 << CH_W)) begin : g_bad_ch
         $error("bfilt_chan: MY_CH does not fit the channel field");
      end
   endgenerate

   lane_info_t    [LANES-1:0]             info;
   lane_verdict_t [LANES-1:0]             verd;
   logic          [LANES-1:0][WORD_W-1:0] lane_word;
   logic          [LANES-1:0]             keep;
   logic          [LANES-1:0][WORD_W-1:0] pk_word;
   logic          [LANES-1:0]             pk_vld;
   logic          [LANES-1:0]             pk_ctl;
   logic                                  act_q, act_d;
   logic          [CH_W-1:0]              own_q, own_d;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [WORD_W-1:0] raw;
      logic [WORD_W-1:0] rebuilt;
      assign raw = in_data[i*WORD_W +: WORD_W];

      bfilt_lane_dec #(.WORD_W(WORD_W)) u_dec (
         .word_i (raw),
         .ctl_i  (in_ctl[i]),
         .info_o (info[i])
      );

      // a kept control word carries only the part that belongs here
      always_comb begin
         rebuilt = raw;
         if (in_ctl[i]) begin
            rebuilt[CW_SOP_BIT]            = verd[i].sop;
            rebuilt[CW_EOP_BIT]            = verd[i].eop;
            rebuilt[CW_CNT_LO +: CNT_W]    = verd[i].eop ? info[i].cnt : '0;
            rebuilt[CW_CH_LO +: CH_W]      = MY_CH_V;
         end
      end

      assign lane_word[i] = rebuilt;
      assign keep[i]      = verd[i].keep;
   end

   bfilt_owner_walk #(.LANES(LANES), .MY_CH(MY_CH_V)) u_walk (
      .info_i     (info),
      .beat_vld_i (in_valid),
      .act_q_i    (act_q),
      .own_q_i    (own_q),
      .verd_o     (verd),
      .act_d_o    (act_d),
      .own_d_o    (own_d)
   );

   bfilt_pack #(.LANES(LANES), .WORD_W(WORD_W)) u_pack (
      .word_i (lane_word),
      .keep_i (keep),
      .ctl_i  (in_ctl),
      .word_o (pk_word),
      .vld_o  (pk_vld),
      .ctl_o  (pk_ctl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= 1'b0;
         own_q    <= '0;
         out_data <= '0;
         out_vld  <= '0;
         out_ctl  <= '0;
      end else begin
         act_q    <= act_d;
         own_q    <= own_d;
         out_data <= pk_word;
         out_vld  <= pk_vld;
         out_ctl  <= pk_ctl;
      end
   end
endmodule

// File: rtl/bfilt_chan_chk.sv
module bfilt_chan_chk #(
   parameter int unsigned LANES  = 4,
   parameter int unsigned WORD_W = 64
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic [LANES*WORD_W-1:0] out_data,
   input logic [LANES-1:0]        out_vld,
   input logic [LANES-1:0]        out_ctl
);
   // first cycle out of reset shows an empty beat
   p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (out_vld == '0));

   // valid lanes form one run starting at the top lane
   p_packed_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (((out_vld << 1) & ~out_vld) == '0));

   // no control flag without a valid word
   p_ctl_in_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_ctl & ~out_vld) == '0));

   for (genvar i = 0; i < LANES; i++) begin : g_zero
      p_idle_lane_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !out_vld[i] |-> (out_data[i*WORD_W +: WORD_W] == '0));
   end

   // an unqualified beat yields nothing
   p_gap_beat_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> (out_vld == '0));
endmodule

bind bfilt_chan bfilt_chan_chk #(.LANES(LANES), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/bfilt_chan_tb.sv
`timescale 1ns/1ps
module bfilt_chan_tb;
   typedef struct packed {
      logic [3:0]   vld;
      logic [3:0]   ctl;
      logic [255:0] dat;
   } beat_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [255:0] in_data = '0;
   logic [3:0]   in_ctl = '0;
   logic [255:0] od0, od1;
   logic [3:0]   ov0, ov1, oc0, oc1;

   int n_chk = 0;
   int n_bad = 0;
   beat_t q0[$];
   beat_t q1[$];
   string qt[$];

   always #4 clk = ~clk;

   bfilt_chan #(.MY_CH(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ctl(in_ctl),
      .out_data(od0), .out_vld(ov0), .out_ctl(oc0));
   bfilt_chan #(.MY_CH(1)) u_dut1 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ctl(in_ctl),
      .out_data(od1), .out_vld(ov1), .out_ctl(oc1));

   // control word: type, sop, eop, count, channel (R4 layout)
   function automatic logic [63:0] cw(input logic b, input logic s, input logic e,
                                       input logic [2:0] n, input logic [7:0] ch);
      cw = '0;
      cw[63] = b; cw[62] = s; cw[61] = e; cw[60:58] = n; cw[55:48] = ch;
   endfunction

   function automatic logic [63:0] dw(input int n);
      dw = {8'hDA, 24'h0, 32'(n)};
   endfunction

   function automatic beat_t mk(input logic [3:0] v, input logic [3:0] c,
                                input logic [63:0] a, input logic [63:0] b,
                                input logic [63:0] x, input logic [63:0] d);
      mk.vld = v; mk.ctl = c; mk.dat = {a, b, x, d};
   endfunction

   localparam beat_t NONE = '0;

   task automatic check(input string tag, input beat_t got, input beat_t exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got vld=%b ctl=%b dat=%h expected vld=%b ctl=%b dat=%h",
                  tag, got.vld, got.ctl, got.dat, exp.vld, exp.ctl, exp.dat);
      end
   endtask

   // driver: one beat, expected result for each filter queued
   task automatic send(input string tag, input logic v, input logic [3:0] c,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] x, input logic [63:0] d,
                       input beat_t e0, input beat_t e1);
      @(negedge clk);
      in_valid = v;
      in_ctl   = c;
      in_data  = {a, b, x, d};
      q0.push_back(e0);
      q1.push_back(e1);
      qt.push_back(tag);
   endtask

   // monitor: output of the beat accepted at this edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q0.size() > 0) begin
            string t;
            t = qt.pop_front();
            check({t, " ch0"}, '{vld: ov0, ctl: oc0, dat: od0}, q0.pop_front());
            check({t, " ch1"}, '{vld: ov1, ctl: oc1, dat: od1}, q1.pop_front());
         end
      end
   end

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #100000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got running expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: empty after reset
      check("R1 reset ch0", '{vld: ov0, ctl: oc0, dat: od0}, NONE);
      check("R1 reset ch1", '{vld: ov1, ctl: oc1, dat: od1}, NONE);

      // R8: data before any burst is dropped
      send("R8 pre-burst", 1, 4'b0000, dw(100), dw(101), dw(102), dw(103), NONE, NONE);

      // interleaved pattern: R2 R5 R6 R7 R9
      send("R2 sop ch0", 1, 4'b1000, cw(1,1,0,0,0), dw(0), dw(1), dw(2),
           mk(4'b1111, 4'b1000, cw(1,1,0,0,0), dw(0), dw(1), dw(2)), NONE);
      send("R5 R7 split", 1, 4'b0010, dw(3), dw(4), cw(1,1,1,5,1), dw(5),
           mk(4'b1110, 4'b0010, dw(3), dw(4), cw(1,0,1,5,0), '0),
           mk(4'b1100, 4'b1000, cw(1,1,0,0,1), dw(5), '0, '0));
      send("R9 R2 ch1 full", 1, 4'b0000, dw(6), dw(7), dw(8), dw(9),
           NONE, mk(4'b1111, 4'b0000, dw(6), dw(7), dw(8), dw(9)));
      send("R6 idle eop", 1, 4'b0011, dw(10), dw(11), cw(0,0,1,3,0), cw(0,0,0,0,0),
           NONE, mk(4'b1110, 4'b0010, dw(10), dw(11), cw(0,0,1,3,1), '0));

      // R11: gap beat ignored, ownership kept
      send("R2 reopen ch0", 1, 4'b1000, cw(1,1,0,0,0), dw(20), dw(21), dw(22),
           mk(4'b1111, 4'b1000, cw(1,1,0,0,0), dw(20), dw(21), dw(22)), NONE);
      send("R11 gap beat", 0, 4'b1000, cw(1,1,0,0,1), dw(40), dw(41), dw(42), NONE, NONE);
      send("R11 owner kept", 1, 4'b0000, dw(23), dw(24), dw(25), dw(26),
           mk(4'b1111, 4'b0000, dw(23), dw(24), dw(25), dw(26)), NONE);

      // R3 R5 R7: two handoffs inside one beat
      send("R3 R5 R7 double", 1, 4'b0101, dw(27), cw(1,1,1,2,1), dw(28), cw(1,1,1,7,0),
           mk(4'b1110, 4'b0110, dw(27), cw(1,0,1,2,0), cw(1,1,0,0,0), '0),
           mk(4'b1110, 4'b1010, cw(1,1,0,0,1), dw(28), cw(1,0,1,7,1), '0));
      send("R9 R3 idle mid", 1, 4'b0100, dw(29), cw(0,0,0,0,0), dw(30), dw(31),
           mk(4'b1111, 4'b0100, dw(29), cw(0,0,0,0,0), dw(30), dw(31)), NONE);
      send("R6 R3 eop gap", 1, 4'b1010, cw(1,0,1,4,0), dw(32), cw(1,1,0,0,1), dw(33),
           mk(4'b1000, 4'b1000, cw(1,0,1,4,0), '0, '0, '0),
           mk(4'b1100, 4'b1000, cw(1,1,0,0,1), dw(33), '0, '0));

      @(negedge clk);
      in_valid = 1'b0;
      in_ctl   = '0;
      in_data  = '0;
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule